// File: doc/BRIEF.md
# SMBus Indexed Block Register Target

This block is an SMBus target that owns a bank of sixteen 8-bit configuration registers. A host reaches the bank with two transaction shapes. An indexed block write carries a starting register index, a byte count and then the data bytes. An indexed block read first writes only the index, then issues a repeated START with the read address. The target answers with a length byte followed by register contents. The length of a read is not chosen by the host on the bus. It is the value held in register 8, which the host may reprogram with an ordinary write.

The block samples SCL and SDA inputs that are already synchronized to its clock. It pulls SDA low through an open-drain enable and never drives it high. Its 7-bit bus address comes from pins, so several copies can share one bus. The rest of the chip reads any register at any time through a combinational parallel port that is independent of bus activity.

Top module: `smb_blockreg_target`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal `addr_sel`, with bit 0 choosing write (0) or read (1). Any other address is not acknowledged, and no further byte is acknowledged until the next START.
- R2: In a write transaction (address+W, index N, count X, data), every byte up to and including the X-th data byte is acknowledged. Data byte k (counting from 0) lands in register N+k.
- R3: A data byte that follows the X-th one is not acknowledged and writes no register. A count of 0 lets no data byte through.
- R4: The register index wraps from 15 to 0. This applies both to write targets and to read contents.
- R5: After address+W, index N and a repeated START with address+R, the target sends a length byte first. It then sends registers N, N+1, ... in turn. Every byte goes out MSB first.
- R6: The length byte equals the current value of register 8. Writing register 8 changes the length byte of later reads.
- R7: When the host does not acknowledge a byte the target sent, the target releases SDA. It does not pull SDA low again until a START.
- R8: Indices 14 and 15 are read-only. Writes aimed at them are acknowledged, and their content stays unchanged.
- R9: After reset, register i holds 0x10+i. The exceptions are register 8, which holds 16 (the bank size), and registers 14 and 15, which hold 0xCE and 0xCF.
- R10: `peek_data` shows register `peek_idx` combinationally, in the same cycle.
- R11: A STOP or START that arrives before a byte's eight bits are complete abandons that byte. No register is changed, and the next transaction works normally.
- R12: The target begins pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Synchronized SCL level |
| sda_in | input | 1 | Synchronized SDA level |
| addr_sel | input | 7 | Bus address chosen by pins |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| peek_idx | input | 4 | Register index for the parallel read port |
| peek_data | output | 8 | Content of register `peek_idx` |

## Verification
The design acts one clock after it sees an SCL edge, because it compares each input with its own registered copy. An acknowledge or a transmitted bit is therefore stable on SDA within one clock of SCL falling. The bench samples SDA two clocks into the SCL-high phase, well after that point. A register write is processed on the SCL fall that opens the acknowledge slot, and the new value shows on the parallel port one clock later. The bench reads `peek_data` only after it has sent the STOP, so every check falls many cycles after the result is due.

// File: rtl/smb_blockreg_pkg.sv
// Package: shared types for the SMBus indexed register target.
// Assumes nothing beyond IEEE 1800-2017 enums.
package smb_blockreg_pkg;

    typedef logic [7:0] byte_t;

    // Protocol phase of the target.
    typedef enum logic [2:0] {
        ST_IDLE,   // no transaction in progress
        ST_ADDR,   // receiving the address byte
        ST_IDX,    // receiving the starting index
        ST_CNT,    // receiving the byte count
        ST_DATA,   // receiving data bytes
        ST_TX,     // sending length byte and register bytes
        ST_IGN     // deaf until the next START
    } smb_state_t;

endpackage

// File: rtl/smb_linecond.sv
// Module: detects bus conditions from the already synchronized SCL/SDA.
// Output pulses last one clock and are combinational from the inputs and
// a one-clock registered copy. Assumes the clock oversamples SCL well.
module smb_linecond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    logic scl_q;
    logic sda_q;

    // Hold previous line levels; idle bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // Classify the change seen this clock.
    always_comb begin
        start_o = scl_i && scl_q && sda_q && !sda_i;
        stop_o  = scl_i && scl_q && !sda_q && sda_i;
        rise_o  = scl_i && !scl_q;
        fall_o  = !scl_i && scl_q;
    end

endmodule

// File: rtl/smb_regfile.sv
// Module: register bank with one write port, two combinational read
// ports and a direct tap on the length register. Read-only entries are
// selected by RO_MASK and never take a write. Reset values are computed.
module smb_regfile #(
    parameter int               NREGS   = 16,
    parameter int               LEN_IDX = 8,
    parameter logic [NREGS-1:0] RO_MASK = 16'hC000,
    localparam int              IW      = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [7:0]    wr_data,
    input  logic [IW-1:0] a_idx,
    output logic [7:0]    a_data,
    input  logic [IW-1:0] b_idx,
    output logic [7:0]    b_data,
    output logic [7:0]    len_o
);
    logic [NREGS-1:0][7:0] regs;

    // Reset value of entry i.
    function automatic logic [7:0] dflt(input int i);
        if (i == LEN_IDX)  return 8'(NREGS);
        if (RO_MASK[i])    return 8'(8'hC0 + i);
        return 8'(8'h10 + i);
    endfunction

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        if (RO_MASK[g]) begin : g_ro
            // Read-only entry: constant content.
            always_ff @(posedge clk) begin
                regs[g] <= dflt(g);
            end
            assert_ro_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
                regs[g] == dflt(g));
        end else begin : g_rw
            // Writable entry: reset default, load on addressed write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[g] <= dflt(g);
                else if (wr_en && wr_idx == IW'(g))
                    regs[g] <= wr_data;
            end
        end
    end

    // Read ports and length tap.
    always_comb begin
        a_data = regs[a_idx];
        b_data = regs[b_idx];
        len_o  = regs[LEN_IDX];
    end

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !RO_MASK[wr_idx]) |=> regs[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/smb_blockreg_target.sv
// Module: SMBus target for indexed block write and indexed block read.
// Assumes scl_in/sda_in are synchronized and the clock runs at least
// eight times faster than SCL. sda_pull is an open-drain low enable.
// No clock stretching, PEC, timeouts or alert.
module smb_blockreg_target
    import smb_blockreg_pkg::*;
#(
    parameter int               NREGS   = 16,
    parameter int               LEN_IDX = 8,
    parameter logic [NREGS-1:0] RO_MASK = 16'hC000,
    localparam int              IW      = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_in,
    input  logic          sda_in,
    input  logic [6:0]    addr_sel,
    output logic          sda_pull,
    input  logic [IW-1:0] peek_idx,
    output logic [7:0]    peek_data
);
    logic       c_start, c_stop, c_rise, c_fall;
    smb_state_t st;
    logic [3:0] bitcnt;
    logic       ack_ph;
    logic       is_read;
    logic       host_ack;
    byte_t      shreg;
    byte_t      txsr;
    byte_t      remain;
    logic [IW-1:0] ptr;
    logic       sda_oe;
    logic       byte_ok;
    logic       wr_en;
    byte_t      tx_rd;
    byte_t      len_val;

    smb_linecond u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_in),
        .sda_i   (sda_in),
        .start_o (c_start),
        .stop_o  (c_stop),
        .rise_o  (c_rise),
        .fall_o  (c_fall)
    );

    smb_regfile #(
        .NREGS   (NREGS),
        .LEN_IDX (LEN_IDX),
        .RO_MASK (RO_MASK)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (ptr),
        .wr_data (shreg),
        .a_idx   (ptr),
        .a_data  (tx_rd),
        .b_idx   (peek_idx),
        .b_data  (peek_data),
        .len_o   (len_val)
    );

    // Decide whether the byte just received earns an ACK.
    always_comb begin
        case (st)
            ST_ADDR: byte_ok = (shreg[7:1] == addr_sel);
            ST_DATA: byte_ok = (remain != 8'd0);
            default: byte_ok = 1'b1;
        endcase
    end

    // Commit a data byte at the start of its ACK slot.
    assign wr_en = (st == ST_DATA) && c_fall && !ack_ph && (bitcnt == 4'd8)
                   && (remain != 8'd0);

    // Protocol engine: receive, acknowledge, transmit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            bitcnt   <= 4'd0;
            ack_ph   <= 1'b0;
            is_read  <= 1'b0;
            host_ack <= 1'b0;
            shreg    <= 8'd0;
            txsr     <= 8'd0;
            remain   <= 8'd0;
            ptr      <= '0;
            sda_oe   <= 1'b0;
        end else if (c_start) begin
            st     <= ST_ADDR;
            bitcnt <= 4'd0;
            ack_ph <= 1'b0;
            sda_oe <= 1'b0;
        end else if (c_stop) begin
            st     <= ST_IDLE;
            bitcnt <= 4'd0;
            ack_ph <= 1'b0;
            sda_oe <= 1'b0;
        end else begin
            case (st)
                ST_IDLE, ST_IGN: begin
                    sda_oe <= 1'b0;
                end
                ST_TX: begin
                    if (c_rise && !ack_ph) begin
                        bitcnt <= bitcnt + 4'd1;
                    end else if (c_rise && ack_ph) begin
                        host_ack <= !sda_in;
                    end else if (c_fall && !ack_ph) begin
                        if (bitcnt == 4'd8) begin
                            sda_oe <= 1'b0;
                            ack_ph <= 1'b1;
                        end else if (bitcnt != 4'd0) begin
                            txsr   <= {txsr[6:0], 1'b0};
                            sda_oe <= !txsr[6];
                        end
                    end else if (c_fall && ack_ph) begin
                        ack_ph <= 1'b0;
                        bitcnt <= 4'd0;
                        if (host_ack) begin
                            txsr   <= tx_rd;
                            sda_oe <= !tx_rd[7];
                            ptr    <= ptr + IW'(1);
                        end else begin
                            st <= ST_IGN;
                        end
                    end
                end
                default: begin
                    if (c_rise && !ack_ph && bitcnt != 4'd8) begin
                        shreg  <= {shreg[6:0], sda_in};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (c_fall && !ack_ph && bitcnt == 4'd8) begin
                        ack_ph <= 1'b1;
                        sda_oe <= byte_ok;
                        case (st)
                            ST_ADDR: is_read <= shreg[0];
                            ST_IDX:  ptr     <= shreg[IW-1:0];
                            ST_CNT:  remain  <= shreg;
                            ST_DATA: if (remain != 8'd0) begin
                                ptr    <= ptr + IW'(1);
                                remain <= remain - 8'd1;
                            end
                            default: ;
                        endcase
                    end else if (c_fall && ack_ph) begin
                        ack_ph <= 1'b0;
                        bitcnt <= 4'd0;
                        sda_oe <= 1'b0;
                        if (!sda_oe) begin
                            st <= ST_IGN;
                        end else begin
                            case (st)
                                ST_ADDR: if (is_read) begin
                                    st     <= ST_TX;
                                    txsr   <= len_val;
                                    sda_oe <= !len_val[7];
                                end else begin
                                    st <= ST_IDX;
                                end
                                ST_IDX:  st <= ST_CNT;
                                ST_CNT:  st <= ST_DATA;
                                default: st <= ST_DATA;
                            endcase
                        end
                    end
                end
            endcase
        end
    end

    assign sda_pull = sda_oe;

    assert_pull_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_in);

    assert_deaf_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IGN) |-> !sda_oe);

    assert_count_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> remain == $past(remain) - 8'd1);

    assert_bitcnt_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt <= 4'd8);

endmodule

// File: tb/sim_smb_blockreg_target.sv
module sim_smb_blockreg_target;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       hsda = 1'b1;
    logic [6:0] addr_sel = 7'h5A;
    logic       sda_pull;
    logic [3:0] peek_idx = 4'd0;
    logic [7:0] peek_data;
    logic       sda_line;
    int         n_chk = 0;
    int         n_fail = 0;
    logic       done = 1'b0;

    localparam logic [6:0] ADDR = 7'h5A;

    // Vector: idx[19:16], data[15:8], expected register after write[7:0].
    localparam logic [19:0] VEC [6] = '{
        {4'd3,  8'h3C, 8'h3C},
        {4'd0,  8'h01, 8'h01},
        {4'd14, 8'h77, 8'hCE},
        {4'd7,  8'hF0, 8'hF0},
        {4'd15, 8'h00, 8'hCF},
        {4'd11, 8'hAB, 8'hAB}
    };

    assign sda_line = hsda & ~sda_pull;

    always #2 clk = ~clk;

    smb_blockreg_target u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl),
        .sda_in    (sda_line),
        .addr_sel  (addr_sel),
        .sda_pull  (sda_pull),
        .peek_idx  (peek_idx),
        .peek_data (peek_data)
    );

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic b_start();
        if (!scl) begin
            hsda = 1'b1; wt(4); scl = 1'b1; wt(4);
        end
        hsda = 1'b0; wt(4); scl = 1'b0; wt(4);
    endtask

    task automatic b_stop();
        hsda = 1'b0; wt(4); scl = 1'b1; wt(4); hsda = 1'b1; wt(4);
    endtask

    task automatic b_wr(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            hsda = b[i]; wt(4); scl = 1'b1; wt(4); scl = 1'b0;
        end
        hsda = 1'b1; wt(4); scl = 1'b1; wt(2);
        ack = ~sda_line;
        wt(2); scl = 1'b0;
    endtask

    task automatic b_rd(input logic ack_it, output logic [7:0] b);
        hsda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(4); scl = 1'b1; wt(2); b[i] = sda_line; wt(2); scl = 1'b0;
        end
        hsda = ~ack_it; wt(4); scl = 1'b1; wt(4); scl = 1'b0;
        hsda = 1'b1;
    endtask

    task automatic wr_txn(input logic [6:0] a, input logic [7:0] idx, input logic [7:0] cnt,
                          input logic [23:0] d, input int n, output logic [5:0] acks);
        logic k;
        acks = '0;
        b_start();
        b_wr({a, 1'b0}, k); acks[0] = k;
        b_wr(idx, k);       acks[1] = k;
        b_wr(cnt, k);       acks[2] = k;
        for (int i = 0; i < n; i++) begin
            b_wr(d[23-8*i -: 8], k); acks[3+i] = k;
        end
        b_stop();
    endtask

    task automatic peek(input logic [3:0] i, output logic [7:0] v);
        peek_idx = i; wt(1); v = peek_data;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; scl = 1'b1; hsda = 1'b1; wt(5); rst_n = 1'b1; wt(2);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [5:0] acks;
        logic [7:0] v;
        logic       k;

        do_reset();

        // R9, R10: reset contents through the parallel port.
        chk("R9 line released after reset", {31'd0, sda_line}, 32'd1);
        for (int i = 0; i < 16; i++) begin
            logic [7:0] e;
            e = (i == 8) ? 8'd16 : (i >= 14) ? 8'(8'hC0 + i) : 8'(8'h10 + i);
            peek(4'(i), v);
            chk("R9/R10 reset value", {24'd0, v}, {24'd0, e});
        end

        // R2, R8: one-byte writes from the vector table.
        for (int t = 0; t < 6; t++) begin
            wr_txn(ADDR, {4'd0, VEC[t][19:16]}, 8'd1, {VEC[t][15:8], 16'd0}, 1, acks);
            chk("R2/R8 acks on single write", {26'd0, acks}, 32'h0F);
            peek(VEC[t][19:16], v);
            chk("R2/R8 register after write", {24'd0, v}, {24'd0, VEC[t][7:0]});
        end

        // R4, R8: block write from 15 wraps to 0 and 1; 15 stays read-only.
        wr_txn(ADDR, 8'd15, 8'd3, 24'h112233, 3, acks);
        chk("R4 acks on wrapping write", {26'd0, acks}, 32'h3F);
        peek(4'd15, v); chk("R8 index 15 unchanged", {24'd0, v}, 32'hCF);
        peek(4'd0, v);  chk("R4 wrapped byte at 0", {24'd0, v}, 32'h22);
        peek(4'd1, v);  chk("R4 wrapped byte at 1", {24'd0, v}, 32'h33);

        // R3: a byte past the count is refused and not stored.
        wr_txn(ADDR, 8'd4, 8'd1, 24'h445500, 2, acks);
        chk("R3 extra byte NACKed", {26'd0, acks}, 32'h0F);
        peek(4'd4, v); chk("R3 counted byte stored", {24'd0, v}, 32'h44);
        peek(4'd5, v); chk("R3 extra byte not stored", {24'd0, v}, 32'h15);

        // R3: zero count lets nothing through.
        wr_txn(ADDR, 8'd6, 8'd0, 24'h990000, 1, acks);
        chk("R3 zero count data NACKed", {26'd0, acks}, 32'h07);
        peek(4'd6, v); chk("R3 zero count no write", {24'd0, v}, 32'h16);

        // R1: foreign address is ignored until the next START.
        wr_txn(7'h11, 8'd6, 8'd1, 24'h990000, 1, acks);
        chk("R1 foreign address all NACK", {26'd0, acks}, 32'h00);
        peek(4'd6, v); chk("R1 foreign write no effect", {24'd0, v}, 32'h16);

        // R6: program read length to 3 through register 8.
        wr_txn(ADDR, 8'd8, 8'd1, 24'h030000, 1, acks);
        chk("R6 length write acks", {26'd0, acks}, 32'h0F);

        // R5, R6, R7: indexed read from 2.
        b_start();
        b_wr({ADDR, 1'b0}, k); chk("R5 read setup addr ACK", {31'd0, k}, 32'd1);
        b_wr(8'd2, k);         chk("R5 read index ACK", {31'd0, k}, 32'd1);
        b_start();
        b_wr({ADDR, 1'b1}, k); chk("R5 read address ACK", {31'd0, k}, 32'd1);
        b_rd(1'b1, v); chk("R6 length byte from register 8", {24'd0, v}, 32'h03);
        b_rd(1'b1, v); chk("R5 byte from index 2", {24'd0, v}, 32'h12);
        b_rd(1'b1, v); chk("R5 byte from index 3", {24'd0, v}, 32'h3C);
        b_rd(1'b0, v); chk("R5 byte from index 4", {24'd0, v}, 32'h44);
        b_rd(1'b0, v); chk("R7 bus released after NACK", {24'd0, v}, 32'hFF);
        b_stop();

        // R5, R4, R9: after reset, length is 16 and read wraps past 15.
        do_reset();
        b_start();
        b_wr({ADDR, 1'b0}, k);
        b_wr(8'd13, k);
        b_start();
        b_wr({ADDR, 1'b1}, k); chk("R5 read address ACK after reset", {31'd0, k}, 32'd1);
        b_rd(1'b1, v); chk("R9 default length byte", {24'd0, v}, 32'h10);
        b_rd(1'b1, v); chk("R5 byte from index 13", {24'd0, v}, 32'h1D);
        b_rd(1'b1, v); chk("R5 byte from index 14", {24'd0, v}, 32'hCE);
        b_rd(1'b1, v); chk("R5 byte from index 15", {24'd0, v}, 32'hCF);
        b_rd(1'b0, v); chk("R4 read wraps to index 0", {24'd0, v}, 32'h10);
        b_stop();

        // R11: STOP after four data bits abandons the byte.
        b_start();
        b_wr({ADDR, 1'b0}, k);
        b_wr(8'd5, k);
        b_wr(8'd1, k);
        for (int i = 0; i < 4; i++) begin
            hsda = i[0]; wt(4); scl = 1'b1; wt(4); scl = 1'b0;
        end
        b_stop();
        peek(4'd5, v); chk("R11 partial byte not stored", {24'd0, v}, 32'h15);
        wr_txn(ADDR, 8'd5, 8'd1, 24'h660000, 1, acks);
        chk("R11 recovery acks", {26'd0, acks}, 32'h0F);
        peek(4'd5, v); chk("R11 recovery write", {24'd0, v}, 32'h66);

        finish_run();
    end

endmodule